// File: doc/BRIEF.md
# Escape Byte Unstuffer

This block sits behind a synchronous byte FIFO and splits one incoming byte stream into two kinds of traffic: payload bytes and in-band commands. A reserved escape value (0x55) prefixes every command. The byte that follows the escape selects the meaning. A second escape stands for one literal 0x55 in the payload. The value 0x01 marks the start of a message. The value 0x00 is an illegal pair. Any other value is a command code. Payload bytes leave on a valid/ready stream. Commands leave as single-cycle strobes that carry their code.

A transmitter may whiten its payload by XOR with 0x55 before it stuffs escapes. When `whiten_en` is high, the block undoes that XOR on payload bytes only, after unescaping. Command codes are never XORed.

Both byte interfaces follow valid/ready rules. A byte moves on a clock edge where valid and ready are both high. The output holds `out_byte` steady while `out_valid` is high and `out_ready` is low. While the output is stalled like that, the block drops `in_ready`, so no input byte is taken. Strobes are not back-pressured; the receiver must take them in the cycle they appear.

Top module: `esc_unstuffer`

## Requirements
- R1: After synchronous reset, `out_valid`, `cmd_valid`, `som_pulse` and `err_pulse` are low and `in_ready` is high.
- R2: A byte other than 0x55, accepted while no escape is pending and with `whiten_en` low, appears unchanged on `out_byte`. Bytes keep their order.
- R3: The pair 0x55 0x55 yields exactly one 0x55 payload byte (before whitening) and no command.
- R4: The pair 0x55 0x01 yields one `cmd_valid` strobe with `cmd_code` 0x01 and one `som_pulse` in the same cycle. It yields no payload byte.
- R5: The pair 0x55 X, where X is not 0x55, 0x01 or 0x00, yields one `cmd_valid` strobe with `cmd_code` equal to X. It yields no payload byte and no `som_pulse`.
- R6: The pair 0x55 0x00 yields one `err_pulse`, with no payload byte and no command. The next byte is decoded with no escape pending.
- R7: With `whiten_en` high, each payload byte is the unescaped byte XOR 0x55 (so 0x55 0x55 gives 0x00). Command codes are not altered.
- R8: An escape stays pending through any number of cycles with `in_valid` low. It is resolved by the next accepted byte.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_byte` stays stable.
- R10: A payload byte appears on `out_valid` in the cycle after the edge that accepted it. Each strobe (`cmd_valid`, `som_pulse`, `err_pulse`) is high for exactly the one cycle after the edge that accepted the second byte of its pair.
- R11: Synchronous reset clears a pending escape. A 0x01 accepted after reset is payload, not a start of message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| whiten_en | input | 1 | Undo XOR 0x55 whitening on payload bytes |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block can take an input byte |
| in_byte | input | 8 | Raw byte from the FIFO |
| out_valid | output | 1 | Payload byte is offered |
| out_ready | input | 1 | Downstream takes the payload byte |
| out_byte | output | 8 | Payload byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Code of the command, valid with `cmd_valid` |
| som_pulse | output | 1 | One-cycle start-of-message strobe |
| err_pulse | output | 1 | One-cycle illegal-pair strobe |

## Verification
Each escape pair is sent on its own: doubled escape, start marker, ordinary codes, and the illegal zero. Each run shows whether the second byte is routed to the payload, the command strobe or the error strobe. Escapes split by idle gaps and by a reset tell a held pending state apart from one that is lost or wrongly kept. A stall on the payload output shows that input acceptance stops and the held byte does not change. A long stream is built by a bench-side whitener and stuffer, with embedded commands, random output stalls and payload values that whiten to the escape. It must come back as the original payload, which separates correct unescape-then-unwhiten ordering from the reverse.

// File: rtl/unstuff_pkg.sv
package unstuff_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ESC  = 1'b1
  } esc_state_e;
endpackage

// File: rtl/unstuff_whiten.sv
module unstuff_whiten #(
  parameter int W = 8,
  parameter logic [W-1:0] KEY = 8'h55
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (KEY == '0) begin : g_bypass
      logic unused_en;
      assign unused_en = en;
      assign q = d;
    end else begin : g_xor
      assign q = en ? (d ^ KEY) : d;
    end
  endgenerate
endmodule

// File: rtl/unstuff_decode.sv
module unstuff_decode
  import unstuff_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] ESC = 8'h55,
  parameter logic [W-1:0] SOM = 8'h01,
  parameter logic [W-1:0] BAD = 8'h00
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         accept,
  input  logic [W-1:0] in_byte,
  output logic         ld,
  output logic [W-1:0] ld_byte,
  output logic         cmd_fire,
  output logic         som_fire,
  output logic         err_fire,
  output logic [W-1:0] code
);
  esc_state_e state, nxt;

  always_comb begin
    nxt      = state;
    ld       = 1'b0;
    ld_byte  = in_byte;
    cmd_fire = 1'b0;
    som_fire = 1'b0;
    err_fire = 1'b0;
    code     = in_byte;
    if (accept) begin
      unique case (state)
        ST_IDLE: begin
          if (in_byte == ESC) nxt = ST_ESC;
          else                ld  = 1'b1;
        end
        ST_ESC: begin
          nxt = ST_IDLE;
          if (in_byte == ESC) begin
            ld      = 1'b1;
            ld_byte = ESC;
          end else if (in_byte == BAD) begin
            err_fire = 1'b1;
          end else begin
            cmd_fire = 1'b1;
            som_fire = (in_byte == SOM);
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R8: pending escape survives idle input cycles
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ESC && !accept) |=> (state == ST_ESC));

  // R11: reset leaves no escape pending
  p_rst_clear_r11: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE));
endmodule

// File: rtl/unstuff_outreg.sv
module unstuff_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_byte,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else if (ld) begin
      out_valid <= 1'b1;
      out_byte  <= ld_byte;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a load never lands on a stalled byte
  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (rst)
    ld |-> !(out_valid && !out_ready));

  // R9: stalled byte holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
endmodule

// File: rtl/unstuff_evtreg.sv
module unstuff_evtreg #(
  parameter int W = 8,
  parameter logic [W-1:0] SOM = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_fire,
  input  logic         som_fire,
  input  logic         err_fire,
  input  logic [W-1:0] code,
  output logic         cmd_valid,
  output logic         som_pulse,
  output logic         err_pulse,
  output logic [W-1:0] cmd_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      som_pulse <= 1'b0;
      err_pulse <= 1'b0;
      cmd_code  <= '0;
    end else begin
      cmd_valid <= cmd_fire;
      som_pulse <= som_fire;
      err_pulse <= err_fire;
      if (cmd_fire) cmd_code <= code;
    end
  end

  // R10: strobes last one cycle
  p_cmd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);

  // R4: start marker travels with its command strobe
  p_som_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    som_pulse |-> (cmd_valid && cmd_code == SOM));

  // R6: illegal pair never raises a command
  p_err_nocmd_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_pulse, cmd_valid}));
endmodule

// File: rtl/esc_unstuffer.sv
module esc_unstuffer #(
  parameter int W = 8,
  parameter logic [W-1:0] ESC = 8'h55,
  parameter logic [W-1:0] SOM = 8'h01,
  parameter logic [W-1:0] BAD = 8'h00,
  parameter logic [W-1:0] WKEY = 8'h55
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         whiten_en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_byte,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_byte,
  output logic         cmd_valid,
  output logic [W-1:0] cmd_code,
  output logic         som_pulse,
  output logic         err_pulse
);
  logic         accept, ld, cmd_fire, som_fire, err_fire;
  logic [W-1:0] ld_raw, ld_clean, code;

  assign in_ready = !(out_valid && !out_ready);
  assign accept   = in_valid && in_ready;

  unstuff_decode #(.W(W), .ESC(ESC), .SOM(SOM), .BAD(BAD)) u_dec (
    .clk(clk), .rst(rst), .accept(accept), .in_byte(in_byte),
    .ld(ld), .ld_byte(ld_raw), .cmd_fire(cmd_fire), .som_fire(som_fire),
    .err_fire(err_fire), .code(code)
  );

  unstuff_whiten #(.W(W), .KEY(WKEY)) u_wht (
    .en(whiten_en), .d(ld_raw), .q(ld_clean)
  );

  unstuff_outreg #(.W(W)) u_out (
    .clk(clk), .rst(rst), .ld(ld), .ld_byte(ld_clean),
    .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte)
  );

  unstuff_evtreg #(.W(W), .SOM(SOM)) u_evt (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .som_fire(som_fire),
    .err_fire(err_fire), .code(code), .cmd_valid(cmd_valid),
    .som_pulse(som_pulse), .err_pulse(err_pulse), .cmd_code(cmd_code)
  );

  // R2: a payload byte appears only after an accepted input byte
  p_data_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(accept));
endmodule

// File: tb/tb_esc_unstuffer.sv
module tb_esc_unstuffer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       whiten_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic       som_pulse;
  logic       err_pulse;

  int checks = 0;
  int errors = 0;
  logic [7:0] got_d[$];
  logic [7:0] got_c[$];
  logic [7:0] exp_d[$];
  logic [7:0] exp_c[$];
  int n_som = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  esc_unstuffer dut (
    .clk(clk), .rst(rst), .whiten_en(whiten_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .som_pulse(som_pulse), .err_pulse(err_pulse)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) got_d.push_back(out_byte);
      if (cmd_valid) got_c.push_back(cmd_code);
      if (som_pulse) n_som++;
      if (err_pulse) n_err++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic clear();
    step(3);
    got_d.delete(); got_c.delete(); exp_d.delete(); exp_c.delete();
    n_som = 0; n_err = 0;
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic compare(input string tag, input int som_e, input int err_e);
    step(4);
    chk(got_d.size() == exp_d.size(), {tag, " data count"}, got_d.size(), exp_d.size());
    if (got_d.size() == exp_d.size())
      for (int i = 0; i < exp_d.size(); i++)
        chk(got_d[i] == exp_d[i], {tag, " data"}, got_d[i], exp_d[i]);
    chk(got_c.size() == exp_c.size(), {tag, " cmd count"}, got_c.size(), exp_c.size());
    if (got_c.size() == exp_c.size())
      for (int i = 0; i < exp_c.size(); i++)
        chk(got_c[i] == exp_c[i], {tag, " cmd code"}, got_c[i], exp_c[i]);
    chk(n_som == som_e, {tag, " som count"}, n_som, som_e);
    chk(n_err == err_e, {tag, " err count"}, n_err, err_e);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(cmd_valid == 1'b0 && som_pulse == 1'b0 && err_pulse == 1'b0,
        "R1 strobes", {cmd_valid, som_pulse, err_pulse}, 0);
  endtask

  task automatic t_plain();
    clear();
    send(8'h12);
    chk(out_valid && out_byte == 8'h12, "R10 data next cycle", out_byte, 8'h12);
    send(8'hA0); send(8'hFF); send(8'h01); send(8'h00);
    exp_d.push_back(8'h12); exp_d.push_back(8'hA0); exp_d.push_back(8'hFF);
    exp_d.push_back(8'h01); exp_d.push_back(8'h00);
    compare("R2 plain", 0, 0);
  endtask

  task automatic t_literal();
    clear();
    send(8'h55); send(8'h55);
    send(8'h55); send(8'h55); send(8'h55); send(8'h55);
    send(8'h33);
    exp_d.push_back(8'h55); exp_d.push_back(8'h55); exp_d.push_back(8'h55);
    exp_d.push_back(8'h33);
    compare("R3 literal", 0, 0);
  endtask

  task automatic t_som();
    clear();
    send(8'h55); send(8'h01);
    chk(cmd_valid && som_pulse && cmd_code == 8'h01, "R10 som strobe",
        {cmd_valid, som_pulse, cmd_code}, {2'b11, 8'h01});
    step(1);
    chk(!cmd_valid && !som_pulse, "R10 strobe one cycle", {cmd_valid, som_pulse}, 0);
    exp_c.push_back(8'h01);
    compare("R4 som", 1, 0);
  endtask

  task automatic t_cmd();
    clear();
    send(8'h55); send(8'h3C);
    send(8'h55); send(8'hFF);
    send(8'h55); send(8'h02);
    exp_c.push_back(8'h3C); exp_c.push_back(8'hFF); exp_c.push_back(8'h02);
    compare("R5 cmd", 0, 0);
  endtask

  task automatic t_bad();
    clear();
    send(8'h55); send(8'h00);
    chk(err_pulse == 1'b1, "R10 err strobe", err_pulse, 1);
    send(8'h01);
    exp_d.push_back(8'h01);
    compare("R6 illegal", 0, 1);
  endtask

  task automatic t_gap();
    clear();
    send(8'h55); step(6); send(8'h55);
    send(8'h55); step(9); send(8'h01);
    exp_d.push_back(8'h55);
    exp_c.push_back(8'h01);
    compare("R8 pending gap", 1, 0);
  endtask

  task automatic t_backpressure();
    clear();
    out_ready = 1'b0;
    send(8'h11);
    in_valid = 1'b1;
    in_byte  = 8'h22;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!in_ready, "R9 in_ready low", in_ready, 0);
      chk(out_valid && out_byte == 8'h11, "R9 held byte", out_byte, 8'h11);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    exp_d.push_back(8'h11); exp_d.push_back(8'h22);
    compare("R9 backpressure", 0, 0);
  endtask

  task automatic t_whiten();
    clear();
    whiten_en = 1'b1;
    send(8'h00);
    send(8'h55); send(8'h55);
    send(8'h55); send(8'h3C);
    send(8'h0F);
    exp_d.push_back(8'h55); exp_d.push_back(8'h00); exp_d.push_back(8'h5A);
    exp_c.push_back(8'h3C);
    compare("R7 whiten", 0, 0);
    whiten_en = 1'b0;
  endtask

  task automatic t_reset_pending();
    clear();
    send(8'h55);
    rst = 1'b1; step(1); rst = 1'b0;
    send(8'h01);
    exp_d.push_back(8'h01);
    compare("R11 reset clears escape", 0, 0);
  endtask

  task automatic t_stream();
    logic [7:0] lf = 8'h9D;
    logic [7:0] p, w;
    clear();
    whiten_en = 1'b1;
    for (int i = 0; i < 80; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      p = (i % 7 == 3) ? 8'h00 : lf;
      out_ready = lf[0];
      step(1);
      out_ready = 1'b1;
      if (i % 10 == 5) begin
        send(8'h55); send(8'h33);
        exp_c.push_back(8'h33);
      end
      w = p ^ 8'h55;
      if (w == 8'h55) begin
        send(8'h55); send(8'h55);
      end else begin
        send(w);
      end
      exp_d.push_back(p);
    end
    compare("R7 R3 R9 stream", 0, 0);
    whiten_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_literal();
    t_som();
    t_cmd();
    t_bad();
    t_gap();
    t_backpressure();
    t_whiten();
    t_reset_pending();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule